// File: doc/BRIEF.md
# Flash Write Completion Poller

This block sits on the host side of a parallel flash and waits for an internal program or erase to finish. Software or a command engine first sends the unlock and command words. It then pulses `start_i` with the word address that was written, the kind of operation and a detection method. From then on the poller reads that single address over a simple request/response port until the flash reports it is ready, or until a time limit for that operation kind runs out.

Two detection methods are built in. The default method watches the status bit that flips on every read while the flash is busy (data bit 6). It declares a read "quiet" when that bit equals the same bit of the previous read. The other method compares data bit 7 with the value the caller says bit 7 of the finished word must hold. The flash can finish at any moment relative to the host's reads, so one quiet read is never enough. The poller needs a detection read followed by two confirming reads, all quiet in a row. Any non-quiet read sends it back to searching.

Each operation kind has its own limit, given in clock cycles. The defaults assume a 100 MHz clock and allow 32 us for a word program, 32 ms for a sector or block erase and 128 ms for a chip erase. On expiry the poller stops and raises a timeout flag that stays set until the next accepted start.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is asserted and right after it is released, `busy_o`, `rd_req_o`, `done_o` and `timeout_o` are all 0.
- R2: A `start_i` pulse while idle is accepted. `busy_o` is 1 from the next cycle, `timeout_o` is 0 from that cycle, and every read goes to the address given with the pulse.
- R3: At most one read is in flight. `rd_req_o` stays high with a stable address until `rd_rdy_i` accepts it. No new request is raised before the response to the accepted one arrives.
- R4: Toggle method (`start_mode_i` = 0): a read is quiet when its bit 6 equals bit 6 of the previous read in the same poll. The first read of a poll only records a baseline and is never quiet.
- R5: Level method (`start_mode_i` = 1): a read is quiet when its bit 7 equals `start_expect_i`, and this includes the first read. Bit 6 is ignored in this method.
- R6: Completion needs three quiet reads in a row: one that detects and two that confirm. A non-quiet read restarts the count. On completion `done_o` is high for exactly one cycle, the same cycle in which `busy_o` drops.
- R7: The limit is chosen by `start_op_i`: 0 selects the word-program limit, 1 the sector/block-erase limit, and 2 or 3 the chip-erase limit.
- R8: A poll that has not completed stays busy for exactly the selected limit in cycles. It then ends with `timeout_o` = 1 and no `done_o` pulse.
- R9: `timeout_o` stays 1 after a timeout until the next accepted start clears it.
- R10: A `start_i` pulse while busy is ignored. Address, method and limit of the running poll stay unchanged.
- R11: A response that arrives while no read is awaited changes nothing: the block stays idle and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a poll |
| start_addr_i | input | AW (20) | Word address to poll |
| start_op_i | input | 2 | Operation kind: 0 program, 1 sector/block erase, 2/3 chip erase |
| start_mode_i | input | 1 | 0 toggle method, 1 level method |
| start_expect_i | input | 1 | Final value of data bit 7 for the level method |
| rd_req_o | output | 1 | Read request valid |
| rd_addr_o | output | AW (20) | Read address |
| rd_rdy_i | input | 1 | Read request accepted this cycle |
| rd_rsp_vld_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | DW (16) | Read data word |
| busy_o | output | 1 | A poll is running |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds the poller with limits of 60, 150 and 300 cycles for the program, erase and chip kinds. With these values a poll that never settles runs into its limit within a few hundred cycles, so the exact busy length can be counted for every operation code. The status patterns are short and scripted: a false stall, a confirmation that fails on its second read, an immediate match, and bit 6 still toggling under the level method. Together they exercise restart of the confirmation count, the baseline read and the ignored start. Response latency and acceptance stalls are varied between runs.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fwp_state_e;

    localparam logic [1:0] OPK_WORD   = 2'd0;
    localparam logic [1:0] OPK_SECTOR = 2'd1;

    localparam logic MODE_TOGGLE = 1'b0;
    localparam logic MODE_LEVEL  = 1'b1;

endpackage

// File: rtl/fwp_limit_sel.sv
module fwp_limit_sel
    import fwp_pkg::*;
#(
    parameter int TW          = 24,
    parameter int PROG_LIMIT  = 3200,
    parameter int ERASE_LIMIT = 3200000,
    parameter int CHIP_LIMIT  = 12800000
) (
    input  logic [1:0]    op_i,
    output logic [TW-1:0] limit_o
);

    always_comb begin
        unique case (op_i)
            OPK_WORD:   limit_o = TW'(PROG_LIMIT);
            OPK_SECTOR: limit_o = TW'(ERASE_LIMIT);
            default:    limit_o = TW'(CHIP_LIMIT);
        endcase
    end

endmodule

// File: rtl/fwp_timer.sv
module fwp_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_i && (cnt_q == limit_i - TW'(1));

    // R8: a running poll never has more elapsed cycles than its limit allows
    p_window_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/fwp_judge.sv
module fwp_judge #(
    parameter int CONFIRM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic fire_i,
    input  logic tog_i,
    input  logic lvl_i,
    input  logic mode_i,
    input  logic exp_bit_i,
    output logic settle_o
);

    localparam int TARGET = CONFIRM + 1;
    localparam int RW     = $clog2(TARGET + 1);

    typedef struct packed {
        logic          prev;
        logic          have_prev;
        logic [RW-1:0] run;
    } judge_t;

    judge_t j_d, j_q;
    logic   quiet;

    always_comb begin
        j_d      = j_q;
        quiet    = 1'b0;
        settle_o = 1'b0;
        if (clear_i) begin
            j_d = '0;
        end else if (fire_i) begin
            if (mode_i) begin
                quiet = (lvl_i == exp_bit_i);
            end else begin
                quiet = j_q.have_prev && (tog_i == j_q.prev);
            end
            if (quiet) begin
                if (j_q.run == RW'(TARGET - 1)) begin
                    settle_o = 1'b1;
                    j_d.run  = '0;
                end else begin
                    j_d.run = j_q.run + RW'(1);
                end
            end else begin
                j_d.run = '0;
            end
            j_d.prev      = tog_i;
            j_d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            j_q <= '0;
        end else begin
            j_q <= j_d;
        end
    end

    // R6: the quiet run never reaches the target without being consumed
    p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        j_q.run < RW'(TARGET));

    // R4: without a recorded baseline the toggle method can never settle
    p_baseline_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !j_q.have_prev) |-> !settle_o);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fwp_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 16,
    parameter int TOG_BIT     = 6,
    parameter int LVL_BIT     = 7,
    parameter int CONFIRM     = 2,
    parameter int PROG_LIMIT  = 3200,
    parameter int ERASE_LIMIT = 3200000,
    parameter int CHIP_LIMIT  = 12800000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [1:0]    start_op_i,
    input  logic          start_mode_i,
    input  logic          start_expect_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_rdy_i,
    input  logic          rd_rsp_vld_i,
    input  logic [DW-1:0] rd_rsp_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          timeout_o
);

    localparam int LIM_PE  = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
    localparam int LIM_MAX = (LIM_PE > CHIP_LIMIT) ? LIM_PE : CHIP_LIMIT;
    localparam int TW      = $clog2(LIM_MAX + 1);

    typedef struct packed {
        fwp_state_e    state;
        logic [AW-1:0] addr;
        logic [1:0]    op;
        logic          mode;
        logic          exp_bit;
        logic          done;
        logic          timeout;
    } core_t;

    core_t         c_d, c_q;
    logic          start_ok;
    logic          rsp_fire;
    logic          settle;
    logic          expired;
    logic [TW-1:0] limit;
    logic          unused_data;

    assign unused_data = ^rd_rsp_data_i;
    assign start_ok    = start_i && (c_q.state == ST_IDLE);
    assign rsp_fire    = (c_q.state == ST_WAIT) && rd_rsp_vld_i;

    fwp_limit_sel #(
        .TW          (TW),
        .PROG_LIMIT  (PROG_LIMIT),
        .ERASE_LIMIT (ERASE_LIMIT),
        .CHIP_LIMIT  (CHIP_LIMIT)
    ) u_lim (
        .op_i    (c_q.op),
        .limit_o (limit)
    );

    fwp_timer #(
        .TW (TW)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_ok),
        .run_i     (c_q.state != ST_IDLE),
        .limit_i   (limit),
        .expired_o (expired)
    );

    fwp_judge #(
        .CONFIRM (CONFIRM)
    ) u_jdg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_ok),
        .fire_i    (rsp_fire),
        .tog_i     (rd_rsp_data_i[TOG_BIT]),
        .lvl_i     (rd_rsp_data_i[LVL_BIT]),
        .mode_i    (c_q.mode),
        .exp_bit_i (c_q.exp_bit),
        .settle_o  (settle)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.state   = ST_ISSUE;
                    c_d.addr    = start_addr_i;
                    c_d.op      = start_op_i;
                    c_d.mode    = start_mode_i;
                    c_d.exp_bit = start_expect_i;
                    c_d.timeout = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (expired) begin
                    c_d.state   = ST_IDLE;
                    c_d.timeout = 1'b1;
                end else if (rd_rdy_i) begin
                    c_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (expired) begin
                    c_d.state   = ST_IDLE;
                    c_d.timeout = 1'b1;
                end else if (rd_rsp_vld_i) begin
                    if (settle) begin
                        c_d.state = ST_IDLE;
                        c_d.done  = 1'b1;
                    end else begin
                        c_d.state = ST_ISSUE;
                    end
                end
            end
            default: begin
                c_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_req_o  = (c_q.state == ST_ISSUE);
    assign rd_addr_o = c_q.addr;
    assign busy_o    = (c_q.state != ST_IDLE);
    assign done_o    = c_q.done;
    assign timeout_o = c_q.timeout;

    // R3: a request that is not accepted stays up with the same address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_rdy_i && !expired) |=> (rd_req_o && $stable(rd_addr_o)));

    // R3: an accepted request is followed by a wait, not a second request
    p_one_inflight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_rdy_i) |=> !rd_req_o);

    // R2: an idle start makes the block busy with the flag cleared
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !timeout_o));

    // R6: completion is a single pulse that coincides with the idle state
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_done_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_rsp_vld_i));

    // R8: a timed-out poll never also reports completion
    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !done_o);

    // R9: the flag holds until a start clears it
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !start_i) |=> timeout_o);

    // R10: a start while busy leaves the polled address alone
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(rd_addr_o));

endmodule

// File: tb/sim_flash_done_poller.sv
module sim_flash_done_poller;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int PL = 60;
    localparam int EL = 150;
    localparam int CL = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [1:0]    op_in = '0;
    logic          mode_in = 1'b0;
    logic          expb_in = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_rdy = 1'b1;
    logic          rsp_vld = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          busy, done, timeout;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_done_poller #(
        .AW (AW), .DW (DW), .PROG_LIMIT (PL), .ERASE_LIMIT (EL), .CHIP_LIMIT (CL)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start_i (start), .start_addr_i (addr_in),
        .start_op_i (op_in), .start_mode_i (mode_in), .start_expect_i (expb_in),
        .rd_req_o (rd_req), .rd_addr_o (rd_addr), .rd_rdy_i (rd_rdy),
        .rd_rsp_vld_i (rsp_vld), .rd_rsp_data_i (rsp_data),
        .busy_o (busy), .done_o (done), .timeout_o (timeout)
    );

    typedef struct {
        logic [AW-1:0] addr;
        bit            exp_done;
        int            exp_reads;
        int            exp_busy;
        string         req;
    } item_t;

    item_t     sb[$];
    int        n_chk = 0;
    int        n_bad = 0;
    bit [31:0] p6 = 32'h0, p7 = 32'h0;
    int        n6 = 1, n7 = 1, lat = 2, ridx = 0;
    bit        stall = 1'b0, stray = 1'b0;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mkword(int k);
        logic [DW-1:0] w;
        w    = 16'h1234;
        w[6] = (k < n6) ? p6[k] : p6[n6-1];
        w[7] = (k < n7) ? p7[k] : p7[n7-1];
        return w;
    endfunction

    // flash read model: one read in flight, scripted status bits
    initial begin : responder
        bit pend;
        int cd;
        int cyc;
        pend = 1'b0; cd = 0; cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            rsp_vld <= 1'b0;
            if (stray) begin
                rsp_vld  <= 1'b1;
                rsp_data <= 16'hFFFF;
                stray = 1'b0;
            end else if (pend) begin
                if (cd == 0) begin
                    rsp_vld  <= 1'b1;
                    rsp_data <= mkword(ridx);
                    ridx++;
                    pend = 1'b0;
                end else begin
                    cd--;
                end
            end
            if (rd_req && rd_rdy) begin
                pend = 1'b1;
                cd   = lat;
            end
            rd_rdy <= stall ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    // monitor: pops the expected outcome when a poll ends
    initial begin : monitor
        bit    prev_busy;
        bit    inflight;
        int    reads;
        int    bcyc;
        item_t it;
        prev_busy = 1'b0; inflight = 1'b0; reads = 0; bcyc = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (busy) bcyc++;
                if (rsp_vld) inflight = 1'b0;
                if (rd_req && rd_rdy) begin
                    check("R3", "request while read in flight", int'(inflight), 0);
                    inflight = 1'b1;
                    reads++;
                    if (sb.size() > 0) check("R10", "read address", int'(rd_addr), int'(sb[0].addr));
                end
                if (prev_busy && !busy) begin
                    if (sb.size() == 0) begin
                        check("R2", "poll ended with none expected", 1, 0);
                    end else begin
                        it = sb.pop_front();
                        check(it.req, "done pulse", int'(done), int'(it.exp_done));
                        check("R8", "timeout flag at end", int'(timeout), int'(!it.exp_done));
                        if (it.exp_reads >= 0) check(it.req, "reads issued", reads, it.exp_reads);
                        if (it.exp_busy >= 0) check("R8", "busy cycles", bcyc, it.exp_busy);
                    end
                    reads = 0;
                    bcyc  = 0;
                end
                prev_busy = busy;
            end
        end
    end

    task automatic run_poll(string req, logic [AW-1:0] a, logic [1:0] op, bit mode, bit expb,
                            bit [31:0] q6, int m6, bit [31:0] q7, int m7, int l, bit st,
                            bit edone, int ereads, int ebusy, bit extra);
        item_t it;
        it.addr = a; it.exp_done = edone; it.exp_reads = ereads;
        it.exp_busy = ebusy; it.req = req;
        sb.push_back(it);
        p6 = q6; n6 = m6; p7 = q7; n7 = m7; lat = l; stall = st; ridx = 0;
        @(negedge clk);
        start = 1'b1; addr_in = a; op_in = op; mode_in = mode; expb_in = expb;
        @(negedge clk);
        start = 1'b0;
        check("R2", "busy after start", int'(busy), 1);
        check("R2", "timeout cleared by start", int'(timeout), 0);
        if (extra) begin
            repeat (3) @(negedge clk);
            start = 1'b1; addr_in = ~a; op_in = 2'd0; mode_in = ~mode;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (14) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "req in reset", int'(rd_req), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "timeout in reset", int'(timeout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "timeout after reset", int'(timeout), 0);

        // toggle method
        run_poll("R6", 20'h01234, 2'd1, 1'b0, 1'b1, 32'hA, 4, 32'h0, 1, 2, 1'b0, 1'b1, 7, -1, 1'b0);
        run_poll("R6", 20'h0ABCD, 2'd1, 1'b0, 1'b1, 32'h16, 5, 32'h0, 1, 2, 1'b1, 1'b1, 8, -1, 1'b0);
        run_poll("R6", 20'h55555, 2'd2, 1'b0, 1'b1, 32'h0E, 5, 32'h0, 1, 0, 1'b0, 1'b1, 8, -1, 1'b0);
        run_poll("R4", 20'h00007, 2'd1, 1'b0, 1'b1, 32'h1, 1, 32'h0, 1, 1, 1'b0, 1'b1, 4, -1, 1'b0);
        // level method, bit 6 still toggling
        run_poll("R5", 20'h10000, 2'd1, 1'b1, 1'b1, 32'hAAAAAAAA, 32, 32'h4, 3, 2, 1'b0, 1'b1, 5, -1, 1'b0);
        run_poll("R5", 20'h10001, 2'd1, 1'b1, 1'b1, 32'hAAAAAAAA, 32, 32'h1, 1, 2, 1'b1, 1'b1, 3, -1, 1'b0);
        run_poll("R5", 20'h10002, 2'd2, 1'b1, 1'b1, 32'hAAAAAAAA, 32, 32'h16, 5, 1, 1'b0, 1'b1, 7, -1, 1'b0);
        run_poll("R5", 20'h10003, 2'd1, 1'b1, 1'b0, 32'hAAAAAAAA, 32, 32'h1, 2, 2, 1'b0, 1'b1, 4, -1, 1'b0);
        // start while busy
        run_poll("R10", 20'h2AAAA, 2'd1, 1'b0, 1'b1, 32'hA, 4, 32'h0, 1, 2, 1'b0, 1'b1, 7, -1, 1'b1);

        // stray response while idle
        stray = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R11", "busy after stray response", int'(busy), 0);
            check("R11", "done after stray response", int'(done), 0);
        end

        // limits per operation code, status never settles in time
        run_poll("R7", 20'h30000, 2'd0, 1'b0, 1'b1, 32'hAAAAAAAA, 32, 32'h0, 1, 8, 1'b1, 1'b0, -1, PL, 1'b0);
        run_poll("R7", 20'h30001, 2'd1, 1'b0, 1'b1, 32'hAAAAAAAA, 32, 32'h0, 1, 8, 1'b1, 1'b0, -1, EL, 1'b0);
        run_poll("R7", 20'h30002, 2'd2, 1'b0, 1'b1, 32'hAAAAAAAA, 32, 32'h0, 1, 8, 1'b0, 1'b0, -1, CL, 1'b0);
        run_poll("R7", 20'h30003, 2'd3, 1'b0, 1'b1, 32'hAAAAAAAA, 32, 32'h0, 1, 8, 1'b0, 1'b0, -1, CL, 1'b0);

        repeat (10) @(negedge clk);
        check("R9", "timeout still set while idle", int'(timeout), 1);
        run_poll("R9", 20'h00042, 2'd1, 1'b0, 1'b1, 32'h0, 1, 32'h0, 1, 2, 1'b0, 1'b1, 4, -1, 1'b0);
        check("R9", "timeout after successful poll", int'(timeout), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule